// File: doc/BRIEF.md
# Three-Channel Output Compare Timer

This block is a free-running up-counter with three compare channels, named A, B and C. The counter advances by one on each clock where the count strobe is high and the run bit is set. Each channel compares its own register against the value that the counter has just reached. On a hit, the channel raises a sticky hit flag and applies its configured action to its output pin: toggle, force high, force low, or leave the pin alone.

The counter can wrap on its own. It can also be sent back to zero on the increment that follows a hit on a chosen channel, which gives a period of compare value plus one. A terminal-count flag records every pass through the all-ones value. If clear-on-A is selected and A's compare value is the all-ones value, the clear and the natural wrap coincide and both raise that flag.

Software reaches the block through a plain single-cycle register write port. Every control input is a level or a one-cycle pulse, so nothing can apply back-pressure. A write is accepted on the clock edge where `wr_en` is high. Results appear only on the status outputs and the pins, which are plain registered levels.

Top module: `tri_compare_timer`

## Requirements
- R1: After reset, `count` is 0, all pins are low, all hit flags and the terminal-count flag are 0, the run bit is 0, and every compare register holds all ones.
- R2: `count` increments by one exactly on clocks where `cnt_en` is 1 and the run bit (address 0, bit 0) is 1. Otherwise `count` and every pin hold their values, and clearing the run bit followed by setting it again resumes counting from the held value.
- R3: A channel hits when an increment makes `count` equal its compare register (addresses 1, 2, 3 for A, B, C). A hit sets that channel's flag (`match_flag` bit 0/1/2). Writing address 5 with a 0 in bit 0/1/2 clears the flag, and a 1 leaves it unchanged. A hit in the same cycle as a clearing write leaves the flag set.
- R4: Address 0 bits 4:2 select the clear source: 001 = A, 010 = B, 011 = C, and any other value means none. On the increment that follows the counter reaching the selected channel's compare value, `count` becomes 0 instead of value plus one.
- R5: An increment from all ones gives 0 and sets `ovf_flag`, including when clear-on-A with an A compare value of all ones causes it. Writing 0 to bit 3 of address 5 clears `ovf_flag`, and a set takes priority over the clear.
- R6: Channels A and B take a 3-bit action code, at address 4 bits 2:0 for A and bits 5:3 for B. The codes are 011 = toggle, 010 = drive high, 001 = drive low, and any other value means no pin change on a hit.
- R7: Channel C takes a 4-bit action code at address 4 bits 9:6. The codes are 1011 = toggle, 1010 = drive high, 1001 = drive low, and 1000 or any other value means no pin change on a hit.
- R8: Address 4 bits 12:10 are the initial levels of A, B and C. A write to address 4 while the run bit is 0 loads each channel's output state from its new level. The same write while running leaves the output states unchanged.
- R9: Address 4 bits 15:13 are active-low output enables for A, B and C. While a channel's enable bit is 1, its pin shows the initial level. While the bit is 0, the pin shows the channel's output state.
- R10: Address 0 bit 1 selects continue-on-hit. When it is 0, any channel hit clears the run bit, so the counter stops at the hit value. When it is 1, counting goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count strobe; one increment per high clock while running |
| wr_en | input | 1 | Register write pulse |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| count | output | CNT_W | Current counter value |
| out_pin | output | 3 | Channel pins: bit 0 = A, bit 1 = B, bit 2 = C |
| match_flag | output | 3 | Sticky hit flags, in the same bit order as the pins |
| ovf_flag | output | 1 | Sticky terminal-count flag |

## Verification
Two events can land in the same cycle: a compare hit, and a software write of 0 that clears the flag of the same channel. The bench brings the counter to one below channel A's compare value. It then raises `cnt_en` and a clearing write to address 5 on a single clock. It judges `match_flag[0]`, which must still read 1 afterwards, and then confirms that a later clearing write with no hit does take effect. A second collision comes from clear-on-A with an all-ones compare value: the clear and the natural wrap fall on one increment, and the bench checks that `count` reads 0 and `ovf_flag` reads 1.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int NCH = 3;
  localparam int AW  = 3;
  localparam int DW  = 16;

  localparam logic [AW-1:0] A_CTRL  = 3'd0;
  localparam logic [AW-1:0] A_CMPA  = 3'd1;
  localparam logic [AW-1:0] A_CHCFG = 3'd4;
  localparam logic [AW-1:0] A_FLAGS = 3'd5;

  localparam int F_ACT_B = 3;
  localparam int F_ACT_C = 6;
  localparam int F_INIT  = 10;
  localparam int F_ENN   = 13;
  localparam int F_OVF   = 3;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  function automatic act_e dec_short(input logic [2:0] code);
    case (code)
      3'b011:  return ACT_TOGGLE;
      3'b010:  return ACT_HIGH;
      3'b001:  return ACT_LOW;
      default: return ACT_NONE;
    endcase
  endfunction

  function automatic act_e dec_long(input logic [3:0] code);
    case (code)
      4'b1011: return ACT_TOGGLE;
      4'b1010: return ACT_HIGH;
      4'b1001: return ACT_LOW;
      default: return ACT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/tct_channel.sv
module tct_channel
  import tct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] nxt,
  input  logic [CNT_W-1:0] cmp,
  input  act_e             act,
  input  logic             init_lvl,
  input  logic             en_n,
  input  logic             init_ld,
  input  logic             ld_val,
  input  logic             flag_wr,
  input  logic             flag_keep,
  output logic             hit,
  output logic             flag,
  output logic             pin
);
  logic state_q;

  // a hit is judged on the value the counter is about to take
  assign hit = tick && (nxt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
    end else if (init_ld) begin
      state_q <= ld_val;
    end else if (hit) begin
      case (act)
        ACT_LOW:    state_q <= 1'b0;
        ACT_HIGH:   state_q <= 1'b1;
        ACT_TOGGLE: state_q <= ~state_q;
        default:    state_q <= state_q;
      endcase
    end
  end

  // a new hit outranks a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    flag <= 1'b0;
    else if (hit)                  flag <= 1'b1;
    else if (flag_wr && !flag_keep) flag <= 1'b0;
  end

  assign pin = en_n ? init_lvl : state_q;
endmodule

// File: rtl/tct_counter.sv
module tct_counter
  import tct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cnt_en,
  input  logic                      run,
  input  logic [2:0]                clr_sel,
  input  logic [NCH-1:0][CNT_W-1:0] cmp,
  input  logic                      flag_wr,
  input  logic                      ovf_keep,
  output logic [CNT_W-1:0]          cnt,
  output logic [CNT_W-1:0]          nxt,
  output logic                      tick,
  output logic                      ovf_flag
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic at_top;
  logic clr_now;

  assign tick   = cnt_en & run;
  assign at_top = (cnt == TOP);

  always_comb begin
    clr_now = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (clr_sel == 3'(i + 1) && cnt == cmp[i]) clr_now = 1'b1;
    end
  end

  assign nxt = (clr_now || at_top) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ovf_flag <= 1'b0;
    else if (tick && at_top)         ovf_flag <= 1'b1;
    else if (flag_wr && !ovf_keep)   ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/tct_regs.sv
module tct_regs
  import tct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic                      stop_req,
  output logic                      run,
  output logic                      cont,
  output logic [2:0]                clr_sel,
  output logic [NCH-1:0][CNT_W-1:0] cmp,
  output act_e [NCH-1:0]            act,
  output logic [NCH-1:0]            init_lvl,
  output logic [NCH-1:0]            en_n,
  output logic                      init_ld,
  output logic                      flag_wr
);
  logic       wr_ctrl;
  logic       wr_cfg;
  logic [2:0] code_a;
  logic [2:0] code_b;
  logic [3:0] code_c;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_cfg  = wr_en && (wr_addr == A_CHCFG);
  assign flag_wr = wr_en && (wr_addr == A_FLAGS);
  assign init_ld = wr_cfg && !run;

  // hardware stop on a hit outranks a software start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cont    <= 1'b0;
      clr_sel <= 3'b000;
    end else begin
      if (stop_req)     run <= 1'b0;
      else if (wr_ctrl) run <= wr_data[0];
      if (wr_ctrl) begin
        cont    <= wr_data[1];
        clr_sel <= wr_data[4:2];
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    localparam logic [AW-1:0] MY_ADDR = A_CMPA + AW'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cmp[i] <= {CNT_W{1'b1}};
      else if (wr_en && wr_addr == MY_ADDR)   cmp[i] <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a   <= '0;
      code_b   <= '0;
      code_c   <= '0;
      init_lvl <= '0;
      en_n     <= '1;
    end else if (wr_cfg) begin
      code_a   <= wr_data[2:0];
      code_b   <= wr_data[F_ACT_B +: 3];
      code_c   <= wr_data[F_ACT_C +: 4];
      init_lvl <= wr_data[F_INIT +: NCH];
      en_n     <= wr_data[F_ENN +: NCH];
    end
  end

  always_comb begin
    act[0] = dec_short(code_a);
    act[1] = dec_short(code_b);
    act[2] = dec_long(code_c);
  end
endmodule

// File: rtl/tri_compare_timer.sv
module tri_compare_timer
  import tct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [15:0]      wr_data,
  output logic [CNT_W-1:0] count,
  output logic [2:0]       out_pin,
  output logic [2:0]       match_flag,
  output logic             ovf_flag
);
  logic                      run_q;
  logic                      cont_q;
  logic [2:0]                clr_sel;
  logic [NCH-1:0][CNT_W-1:0] cmp;
  act_e [NCH-1:0]            act;
  logic [NCH-1:0]            init_lvl;
  logic [NCH-1:0]            en_n;
  logic                      init_ld;
  logic                      flag_wr;
  logic [CNT_W-1:0]          nxt;
  logic                      tick;
  logic [NCH-1:0]            hit;
  logic                      stop_req;

  assign stop_req = !cont_q && (|hit);

  tct_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .stop_req (stop_req),
    .run      (run_q),
    .cont     (cont_q),
    .clr_sel  (clr_sel),
    .cmp      (cmp),
    .act      (act),
    .init_lvl (init_lvl),
    .en_n     (en_n),
    .init_ld  (init_ld),
    .flag_wr  (flag_wr)
  );

  tct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .run      (run_q),
    .clr_sel  (clr_sel),
    .cmp      (cmp),
    .flag_wr  (flag_wr),
    .ovf_keep (wr_data[F_OVF]),
    .cnt      (count),
    .nxt      (nxt),
    .tick     (tick),
    .ovf_flag (ovf_flag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .nxt       (nxt),
      .cmp       (cmp[i]),
      .act       (act[i]),
      .init_lvl  (init_lvl[i]),
      .en_n      (en_n[i]),
      .init_ld   (init_ld),
      .ld_val    (wr_data[F_INIT + i]),
      .flag_wr   (flag_wr),
      .flag_keep (wr_data[i]),
      .hit       (hit[i]),
      .flag      (match_flag[i]),
      .pin       (out_pin[i])
    );
  end
endmodule

// File: rtl/tct_checker.sv
module tct_checker
  import tct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic             run,
  input logic             cont,
  input logic [2:0]       clr_sel,
  input logic [CNT_W-1:0] count,
  input logic [2:0]       out_pin,
  input logic [2:0]       match_flag,
  input logic [2:0]       hit,
  input logic             ovf_flag
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_en && run) |=> count == $past(count)); // R2

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && run && clr_sel == 3'b000 && count != TOP) |=> count == $past(count) + 1'b1); // R2

  AST_PINS_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(out_pin)); // R2

  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && run && count == TOP) |=> (count == '0 && ovf_flag)); // R5

  AST_STOP_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit && !cont) |=> !run); // R10

  for (genvar i = 0; i < 3; i++) begin : g_flag
    AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> match_flag[i]); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag[i] && !(wr_en && wr_addr == A_FLAGS)) |=> match_flag[i]); // R3
  end
endmodule

bind tri_compare_timer tct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_en     (cnt_en),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .run        (run_q),
  .cont       (cont_q),
  .clr_sel    (clr_sel),
  .count      (count),
  .out_pin    (out_pin),
  .match_flag (match_flag),
  .hit        (hit),
  .ovf_flag   (ovf_flag)
);

// File: tb/tri_compare_timer_tb.sv
module tri_compare_timer_tb;
  import tct_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [2:0]  out_pin;
  logic [2:0]  match_flag;
  logic        ovf_flag;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tri_compare_timer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .count      (count),
    .out_pin    (out_pin),
    .match_flag (match_flag),
    .ovf_flag   (ovf_flag)
  );

  // fields: [12:10] A code, [9] A initial level, [8:5] strobes, [4] pin, [3:0] count
  localparam logic [12:0] VEC [8] = '{
    {3'b011, 1'b0, 4'd3, 1'b1, 4'd3},
    {3'b011, 1'b0, 4'd7, 1'b0, 4'd3},
    {3'b011, 1'b1, 4'd3, 1'b0, 4'd3},
    {3'b010, 1'b0, 4'd2, 1'b0, 4'd2},
    {3'b010, 1'b0, 4'd3, 1'b1, 4'd3},
    {3'b001, 1'b1, 4'd3, 1'b0, 4'd3},
    {3'b000, 1'b1, 4'd7, 1'b1, 4'd3},
    {3'b111, 1'b0, 4'd7, 1'b0, 4'd3}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every task starts and ends at a falling edge
  task automatic do_reset;
    rst_n = 1'b0; cnt_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    if (n > 0) begin
      cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset;
    // R1 reset state
    chk("R1", "count", 32'(count), 32'h0);
    chk("R1", "pins", 32'(out_pin), 32'h0);
    chk("R1", "flags", 32'(match_flag), 32'h0);
    chk("R1", "ovf", 32'(ovf_flag), 32'h0);

    // R6 / R4 table: A compare 3, clear on A, continue set
    for (int k = 0; k < 8; k++) begin
      do_reset;
      wr(A_CHCFG, {5'b00000, VEC[k][9], 7'b0000000, VEC[k][12:10]});
      wr(A_CMPA, 16'd3);
      wr(A_CTRL, 16'h0007);
      step(int'(VEC[k][8:5]));
      chk("R6", $sformatf("vec%0d pin A", k), 32'(out_pin[0]), 32'(VEC[k][4]));
      chk("R4", $sformatf("vec%0d count", k), 32'(count), 32'(VEC[k][3:0]));
    end

    // R2: idle strobe, stop and restart
    do_reset;
    wr(A_CTRL, 16'h0003);
    step(3);
    chk("R2", "count after 3", 32'(count), 32'd3);
    repeat (3) @(negedge clk);
    chk("R2", "no strobe holds", 32'(count), 32'd3);
    wr(A_CTRL, 16'h0002);
    step(4);
    chk("R2", "stopped holds", 32'(count), 32'd3);
    wr(A_CTRL, 16'h0003);
    step(2);
    chk("R2", "resumes", 32'(count), 32'd5);

    // R3: sticky flag, write-1 keeps, clear collides with hit
    do_reset;
    wr(A_CMPA, 16'd4);
    wr(A_CTRL, 16'h0003);
    step(3);
    chk("R3", "no hit yet", 32'(match_flag[0]), 32'h0);
    cnt_en = 1'b1; wr_en = 1'b1; wr_addr = A_FLAGS; wr_data = 16'h0000;
    @(negedge clk);
    cnt_en = 1'b0; wr_en = 1'b0;
    chk("R3", "hit beats clear", 32'(match_flag[0]), 32'h1);
    wr(A_FLAGS, 16'h000F);
    chk("R3", "write 1 keeps", 32'(match_flag[0]), 32'h1);
    wr(A_FLAGS, 16'h0000);
    chk("R3", "write 0 clears", 32'(match_flag[0]), 32'h0);

    // R4: clear on B, clear on C, no clear
    do_reset;
    wr(A_CMPA + 3'd1, 16'd5);
    wr(A_CTRL, 16'h000B);
    step(6);
    chk("R4", "clear on B", 32'(count), 32'd0);
    do_reset;
    wr(A_CMPA + 3'd2, 16'd2);
    wr(A_CTRL, 16'h000F);
    step(3);
    chk("R4", "clear on C", 32'(count), 32'd0);
    do_reset;
    wr(A_CMPA, 16'd2);
    wr(A_CTRL, 16'h0003);
    step(4);
    chk("R4", "no clear source", 32'(count), 32'd4);

    // R10: continue off stops at hit
    do_reset;
    wr(A_CMPA + 3'd1, 16'd2);
    wr(A_CTRL, 16'h0001);
    step(5);
    chk("R10", "stopped at hit", 32'(count), 32'd2);
    chk("R10", "flag B", 32'(match_flag[1]), 32'h1);

    // R7: channel C codes, compare 1
    do_reset;
    wr(A_CHCFG, 16'h1240);
    wr(A_CMPA + 3'd2, 16'd1);
    chk("R8", "C loaded high while stopped", 32'(out_pin[2]), 32'h1);
    wr(A_CTRL, 16'h0003);
    step(1);
    chk("R7", "1001 drives low", 32'(out_pin[2]), 32'h0);
    do_reset;
    wr(A_CHCFG, 16'h0280);
    wr(A_CMPA + 3'd2, 16'd1);
    wr(A_CTRL, 16'h0003);
    step(1);
    chk("R7", "1010 drives high", 32'(out_pin[2]), 32'h1);
    do_reset;
    wr(A_CHCFG, 16'h1200);
    wr(A_CMPA + 3'd2, 16'd1);
    wr(A_CTRL, 16'h0003);
    step(1);
    chk("R7", "1000 leaves pin", 32'(out_pin[2]), 32'h1);
    chk("R7", "flag C still set", 32'(match_flag[2]), 32'h1);

    // R8: initial level reload only while stopped
    do_reset;
    wr(A_CHCFG, 16'h0400);
    chk("R8", "load while stopped", 32'(out_pin[0]), 32'h1);
    wr(A_CTRL, 16'h0003);
    wr(A_CHCFG, 16'h0000);
    chk("R8", "no load while running", 32'(out_pin[0]), 32'h1);
    wr(A_CTRL, 16'h0002);
    wr(A_CHCFG, 16'h0000);
    chk("R8", "reload after stop", 32'(out_pin[0]), 32'h0);

    // R9: disabled pin shows initial level, enable reveals state
    do_reset;
    wr(A_CHCFG, 16'h2003);
    wr(A_CMPA, 16'd1);
    wr(A_CTRL, 16'h0003);
    step(1);
    chk("R9", "disabled shows init", 32'(out_pin[0]), 32'h0);
    wr(A_CHCFG, 16'h0003);
    chk("R9", "enabled shows toggled", 32'(out_pin[0]), 32'h1);

    // R5: all-ones compare with clear on A
    do_reset;
    wr(A_CTRL, 16'h0007);
    step(65535);
    chk("R5", "reached top", 32'(count), 32'hFFFF);
    chk("R5", "no ovf yet", 32'(ovf_flag), 32'h0);
    chk("R3", "hit at top", 32'(match_flag[0]), 32'h1);
    step(1);
    chk("R5", "wrapped", 32'(count), 32'h0);
    chk("R5", "ovf set", 32'(ovf_flag), 32'h1);
    wr(A_FLAGS, 16'h0007);
    chk("R5", "ovf cleared", 32'(ovf_flag), 32'h0);
    chk("R5", "hit flag kept", 32'(match_flag[0]), 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule